// File: doc/BRIEF.md
# Profile-Driven Waveform Sample Sequencer

This block plays stored 32-bit samples out of a 1024-word memory, one at a time, to drive the control words of an oscillator. A sample can drive the frequency word, the phase word or the amplitude word. In polar form, one sample drives both phase and amplitude. The pace of playback comes from a rate timer that reloads for every sample.

Eight profiles are held in registers that are written through a simple write port. Each profile has a start address, an end address, a step rate and a destination code. A 3-bit select input picks the active profile. Playback starts when the enable input is high and either an update strobe arrives or the select input changes. A change is judged against the value the select input had at the previous clock edge.

Inside, a state machine moves through five states:

- **IDLE**: nothing has started since reset.
- **PRIME**: the memory is reading the start address.
- **EMIT**: a sample is presented on the outputs.
- **WAIT**: the rate timer counts down.
- **HOLD**: the last sample stays on the outputs.

The transitions are:

- **start**: from any state to PRIME, on a trigger.
- **primed**: from PRIME to EMIT.
- **pace**: from EMIT to WAIT, when the step rate is above 1.
- **burst**: from EMIT to EMIT, when the step rate is 1.
- **expire**: from WAIT to EMIT.
- **finish**: from EMIT to HOLD, when the end address has been emitted.

Top module: `wavram_player`

## Requirements
- R1: While reset is low, and after it is released, `freq_out`, `phase_out` and `amp_out` are 0 and `smp_valid` and `done` are low until the first trigger.
- R2: With `play_en` low, an `update` pulse or a change of `prof_sel` starts nothing: no `smp_valid` follows, and `done` keeps its value.
- R3: A trigger is `play_en` high at a clock edge together with `update` high or `prof_sel` different from its value at the previous edge. On a trigger, the profile named by `prof_sel` at that edge is loaded. The first `smp_valid` comes at the second edge after the trigger edge and carries the word at the start address.
- R4: Successive `smp_valid` strobes are exactly max(step rate, 1) cycles apart. A step rate of 0 therefore gives one sample every cycle.
- R5: The address rises by one for each sample and wraps from 1023 to 0. Playback ends after the sample at the end address.
- R6: `done` rises at the same edge as the last `smp_valid`. After that, the outputs hold and no `smp_valid` occurs until the next trigger. A trigger clears `done` at its edge.
- R7: Destination code 0 (frequency) sets `freq_out` to the whole 32-bit sample. `phase_out` and `amp_out` keep their values.
- R8: Destination code 1 (phase) sets `phase_out` to sample bits [31:16]. Destination code 2 (amplitude) sets `amp_out` to sample bits [31:18]. Outputs that are not selected keep their values.
- R9: Destination code 3 (polar) sets `phase_out` to sample bits [31:16] and `amp_out` to sample bits [15:2] from the same sample. `freq_out` keeps its value.
- R10: A write with `cfg_we` high stores the start address, end address, step rate and destination into profile `cfg_sel`. A change of `prof_sel` alone, with `play_en` high, starts that profile.
- R11: Outputs change only at an edge where `smp_valid` is raised. `smp_valid` is high for one cycle per sample.
- R12: A trigger at the edge where a sample would be emitted has priority. That edge raises no `smp_valid`, leaves `done` low and leaves the outputs unchanged, and playback restarts from the start address two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Profile register write strobe |
| cfg_sel | input | 3 | Profile number written |
| cfg_start | input | 10 | Start address to store |
| cfg_stop | input | 10 | End address to store |
| cfg_rate | input | 16 | Step-rate count to store |
| cfg_dest | input | 2 | Destination code to store (0 freq, 1 phase, 2 amp, 3 polar) |
| mem_we | input | 1 | Sample memory write strobe |
| mem_addr | input | 10 | Sample memory write address |
| mem_wdata | input | 32 | Sample memory write data |
| play_en | input | 1 | Arms playback starts |
| update | input | 1 | Update strobe that starts playback |
| prof_sel | input | 3 | Active profile select |
| freq_out | output | 32 | Frequency control word |
| phase_out | output | 16 | Phase control word |
| amp_out | output | 14 | Amplitude control word |
| smp_valid | output | 1 | One-cycle strobe per presented sample |
| done | output | 1 | Last sample reached and held |

## Verification
Two functions can fall on the same edge: emitting a sample and accepting a fresh trigger. The bench provokes this by raising `update` on exactly the edge where the final sample of a three-sample run is due. It then judges that no strobe and no `done` appear at that edge and that the held word is unchanged. It also checks that the restart delivers the start-address word two edges later. The table-driven runs and the later directed cases add more overlaps of this kind: a trigger that is a select change and an update at once, and a step rate of 1, where emitting and fetching the next word happen on every edge.

// File: rtl/wavram_pkg.sv
package wavram_pkg;

    typedef enum logic [1:0] {
        DST_FREQ  = 2'd0,
        DST_PHASE = 2'd1,
        DST_AMP   = 2'd2,
        DST_POLAR = 2'd3
    } dest_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRIME,
        S_EMIT,
        S_WAIT,
        S_HOLD
    } seq_state_e;

endpackage

// File: rtl/wavram_prof_bank.sv
module wavram_prof_bank #(
    parameter int NPROF = 8,
    parameter int AW    = 10,
    parameter int RW    = 16,
    localparam int SW   = $clog2(NPROF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [AW-1:0] w_start,
    input  logic [AW-1:0] w_stop,
    input  logic [RW-1:0] w_rate,
    input  logic [1:0]    w_dest,
    input  logic [SW-1:0] rsel,
    output logic [AW-1:0] r_start,
    output logic [AW-1:0] r_stop,
    output logic [RW-1:0] r_rate,
    output logic [1:0]    r_dest
);

    logic [AW-1:0] start_q [NPROF];
    logic [AW-1:0] stop_q  [NPROF];
    logic [RW-1:0] rate_q  [NPROF];
    logic [1:0]    dest_q  [NPROF];

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[p] <= '0;
                stop_q[p]  <= '0;
                rate_q[p]  <= '0;
                dest_q[p]  <= '0;
            end else if (we && (wsel == SW'(p))) begin
                start_q[p] <= w_start;
                stop_q[p]  <= w_stop;
                rate_q[p]  <= w_rate;
                dest_q[p]  <= w_dest;
            end
        end
    end

    assign r_start = start_q[rsel];
    assign r_stop  = stop_q[rsel];
    assign r_rate  = rate_q[rsel];
    assign r_dest  = dest_q[rsel];

endmodule

// File: rtl/wavram_store.sv
module wavram_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/wavram_seq.sv
module wavram_seq
    import wavram_pkg::*;
#(
    parameter int AW  = 10,
    parameter int DW  = 32,
    parameter int RW  = 16,
    parameter int SW  = 3,
    parameter int PHW = 16,
    parameter int AMW = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           play_en,
    input  logic           update,
    input  logic [SW-1:0]  prof_sel,
    input  logic [AW-1:0]  p_start,
    input  logic [AW-1:0]  p_stop,
    input  logic [RW-1:0]  p_rate,
    input  logic [1:0]     p_dest,
    output logic [AW-1:0]  rd_addr,
    input  logic [DW-1:0]  rdata,
    output logic [DW-1:0]  freq_out,
    output logic [PHW-1:0] phase_out,
    output logic [AMW-1:0] amp_out,
    output logic           smp_valid,
    output logic           done
);

    localparam int PH_TOP  = DW - 1;
    localparam int POL_AMP = DW - PHW - 1;

    seq_state_e    state, nxt;
    logic [SW-1:0] prof_q;
    logic [AW-1:0] addr;
    logic [AW-1:0] lat_stop;
    logic [RW-1:0] lat_rate;
    logic [RW-1:0] cnt;
    dest_e         lat_dest;
    logic          trig;
    logic          last;

    assign trig = play_en && (update || (prof_sel != prof_q));
    assign last = (addr == lat_stop);

    // Look one word ahead while emitting so a step rate of 1 never starves.
    assign rd_addr = (state == S_EMIT && !last) ? addr + 1'b1 : addr;

    always_comb begin
        nxt = state;
        if (trig) begin
            nxt = S_PRIME;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_PRIME: nxt = S_EMIT;
                S_EMIT: begin
                    if (last)                    nxt = S_HOLD;
                    else if (lat_rate == RW'(1)) nxt = S_EMIT;
                    else                         nxt = S_WAIT;
                end
                S_WAIT:  nxt = (cnt == RW'(1)) ? S_EMIT : S_WAIT;
                S_HOLD:  nxt = S_HOLD;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            prof_q <= '0;
        end else begin
            state  <= nxt;
            prof_q <= prof_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            lat_stop  <= '0;
            lat_rate  <= RW'(1);
            lat_dest  <= DST_FREQ;
            cnt       <= '0;
            freq_out  <= '0;
            phase_out <= '0;
            amp_out   <= '0;
            smp_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (trig) begin
                addr     <= p_start;
                lat_stop <= p_stop;
                lat_rate <= (p_rate == '0) ? RW'(1) : p_rate;
                lat_dest <= dest_e'(p_dest);
                done     <= 1'b0;
            end else begin
                unique case (state)
                    S_EMIT: begin
                        smp_valid <= 1'b1;
                        unique case (lat_dest)
                            DST_FREQ:  freq_out  <= rdata;
                            DST_PHASE: phase_out <= rdata[PH_TOP -: PHW];
                            DST_AMP:   amp_out   <= rdata[PH_TOP -: AMW];
                            DST_POLAR: begin
                                phase_out <= rdata[PH_TOP -: PHW];
                                amp_out   <= rdata[POL_AMP -: AMW];
                            end
                        endcase
                        if (last) begin
                            done <= 1'b1;
                        end else begin
                            addr <= addr + 1'b1;
                            cnt  <= lat_rate - RW'(1);
                        end
                    end
                    S_WAIT:  cnt <= cnt - RW'(1);
                    S_IDLE, S_PRIME, S_HOLD: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/wavram_player.sv
module wavram_player #(
    parameter int NPROF = 8,
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    parameter int RW    = 16,
    parameter int PHW   = 16,
    parameter int AMW   = 14,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(NPROF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [SW-1:0]  cfg_sel,
    input  logic [AW-1:0]  cfg_start,
    input  logic [AW-1:0]  cfg_stop,
    input  logic [RW-1:0]  cfg_rate,
    input  logic [1:0]     cfg_dest,
    input  logic           mem_we,
    input  logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_wdata,
    input  logic           play_en,
    input  logic           update,
    input  logic [SW-1:0]  prof_sel,
    output logic [DW-1:0]  freq_out,
    output logic [PHW-1:0] phase_out,
    output logic [AMW-1:0] amp_out,
    output logic           smp_valid,
    output logic           done
);

    logic [AW-1:0] p_start, p_stop, rd_addr;
    logic [RW-1:0] p_rate;
    logic [1:0]    p_dest;
    logic [DW-1:0] rdata;

    wavram_prof_bank #(.NPROF(NPROF), .AW(AW), .RW(RW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wsel    (cfg_sel),
        .w_start (cfg_start),
        .w_stop  (cfg_stop),
        .w_rate  (cfg_rate),
        .w_dest  (cfg_dest),
        .rsel    (prof_sel),
        .r_start (p_start),
        .r_stop  (p_stop),
        .r_rate  (p_rate),
        .r_dest  (p_dest)
    );

    wavram_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    wavram_seq #(
        .AW(AW), .DW(DW), .RW(RW), .SW(SW), .PHW(PHW), .AMW(AMW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .play_en   (play_en),
        .update    (update),
        .prof_sel  (prof_sel),
        .p_start   (p_start),
        .p_stop    (p_stop),
        .p_rate    (p_rate),
        .p_dest    (p_dest),
        .rd_addr   (rd_addr),
        .rdata     (rdata),
        .freq_out  (freq_out),
        .phase_out (phase_out),
        .amp_out   (amp_out),
        .smp_valid (smp_valid),
        .done      (done)
    );

endmodule

// File: rtl/wavram_player_chk.sv
module wavram_player_chk #(
    parameter int DW  = 32,
    parameter int PHW = 16,
    parameter int AMW = 14
) (
    input logic           clk,
    input logic           rst_n,
    input logic           play_en,
    input logic [DW-1:0]  freq_out,
    input logic [PHW-1:0] phase_out,
    input logic [AMW-1:0] amp_out,
    input logic           smp_valid,
    input logic           done
);

    // R1: first edge out of reset shows a quiet block
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!smp_valid && !done && freq_out == '0 &&
                           phase_out == '0 && amp_out == '0));

    // R2: without the enable, a finished run stays finished
    assert_no_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !play_en) |=> done);

    // R6: the held run neither strobes nor moves its outputs
    assert_hold_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !play_en) |=> (!smp_valid && $stable(freq_out) &&
                                $stable(phase_out) && $stable(amp_out)));

    // R6: done can only appear together with the final sample
    assert_done_with_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> smp_valid);

    // R11: outputs move only alongside a strobe
    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(freq_out) && $stable(phase_out) && $stable(amp_out)));

endmodule

bind wavram_player wavram_player_chk #(.DW(DW), .PHW(PHW), .AMW(AMW)) u_chk (.*);

// File: tb/tb_wavram_player.sv
module tb_wavram_player;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [9:0]  cfg_start = '0, cfg_stop = '0;
    logic [15:0] cfg_rate = '0;
    logic [1:0]  cfg_dest = '0;
    logic        mem_we = 1'b0;
    logic [9:0]  mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic        play_en = 1'b0, update = 1'b0;
    logic [2:0]  prof_sel = '0;
    logic [31:0] freq_out;
    logic [15:0] phase_out;
    logic [13:0] amp_out;
    logic        smp_valid, done;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mf = '0;
    logic [15:0] mp = '0;
    logic [13:0] ma = '0;

    always #2 clk = ~clk;

    wavram_player dut (.*);

    // {profile, start, end, rate, dest}
    localparam logic [40:0] VEC [4] = '{
        {3'd0, 10'd0,    10'd3,   16'd3, 2'd0},
        {3'd1, 10'd100,  10'd102, 16'd1, 2'd1},
        {3'd2, 10'd500,  10'd503, 16'd2, 2'd2},
        {3'd3, 10'd1022, 10'd1,   16'd2, 2'd3}
    };

    function automatic logic [31:0] pat(input logic [9:0] a);
        logic [31:0] x;
        x = {22'd0, a} * 32'h9E3779B1;
        return x ^ 32'h5A5AC3C3;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic cfg(input logic [2:0] i, input logic [9:0] s, input logic [9:0] e,
                       input logic [15:0] r, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = i; cfg_start = s; cfg_stop = e; cfg_rate = r; cfg_dest = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic route(input logic [1:0] d, input logic [31:0] w);
        case (d)
            2'd0: mf = w;
            2'd1: mp = w[31:16];
            2'd2: ma = w[31:18];
            default: begin mp = w[31:16]; ma = w[15:2]; end
        endcase
    endtask

    task automatic play(input logic [2:0] i, input logic [9:0] s, input logic [9:0] e,
                        input logic [15:0] r, input logic [1:0] d, input bit use_upd);
        int n, cnt, reff;
        logic [9:0] a;
        string rq;
        rq = (d == 2'd0) ? "R7" : (d == 2'd3) ? "R9" : "R8";
        reff = (r == 16'd0) ? 1 : int'(r);
        n = int'(10'(e - s)) + 1;
        a = s;
        @(negedge clk);
        prof_sel = i; play_en = 1'b1; update = use_upd;
        @(negedge clk);
        update = 1'b0;
        cnt = 1;
        for (int j = 0; j < n; j++) begin
            while (!smp_valid && cnt < 200) begin
                @(negedge clk);
                cnt++;
            end
            if (j == 0) chk(cnt == 3, "R3", "first strobe delay", 32'(cnt), 32'd3);
            else        chk(cnt == reff, "R4", "strobe spacing", 32'(cnt), 32'(reff));
            route(d, pat(a));
            chk(freq_out == mf && phase_out == mp && amp_out == ma, rq,
                "routed word (R5 address order)",
                {phase_out, amp_out, 2'b0} ^ freq_out, {mp, ma, 2'b0} ^ mf);
            chk(done == (j == n - 1), "R6", "done with last sample", 32'(done),
                32'(j == n - 1));
            a = a + 10'd1;
            @(negedge clk);
            cnt = 1;
        end
        chk(!smp_valid && done && freq_out == mf && phase_out == mp && amp_out == ma,
            "R11", "held after end", {31'd0, smp_valid}, 32'd0);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(freq_out == 0 && phase_out == 0 && amp_out == 0 && !smp_valid && !done,
            "R1", "outputs in reset", freq_out, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 1024; a++) begin
            @(negedge clk);
            mem_we = 1'b1; mem_addr = 10'(a); mem_wdata = pat(10'(a));
        end
        @(negedge clk);
        mem_we = 1'b0;
        chk(!smp_valid && !done && freq_out == 0, "R1", "quiet after reset", freq_out, 32'd0);

        // Table-driven runs (R3..R9, R10 via the config port)
        foreach (VEC[k]) begin
            cfg(VEC[k][40:38], VEC[k][37:28], VEC[k][27:18], VEC[k][17:2], VEC[k][1:0]);
            play(VEC[k][40:38], VEC[k][37:28], VEC[k][27:18], VEC[k][17:2], VEC[k][1:0], 1'b1);
        end

        // R4: step rate 0 behaves as 1
        cfg(3'd4, 10'd7, 10'd9, 16'd0, 2'd0);
        play(3'd4, 10'd7, 10'd9, 16'd0, 2'd0, 1'b1);

        // R2: disabled triggers are ignored
        @(negedge clk);
        play_en = 1'b0; update = 1'b1; prof_sel = 3'd2;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            update = 1'b0;
            chk(!smp_valid && done && freq_out == mf && phase_out == mp,
                "R2", "disabled trigger", {30'd0, smp_valid, done}, 32'd1);
        end

        // R10: select change alone starts a freshly written profile
        cfg(3'd5, 10'd200, 10'd201, 16'd1, 2'd1);
        play(3'd5, 10'd200, 10'd201, 16'd1, 2'd1, 1'b0);

        // R12: trigger lands on the final sample's emission edge
        cfg(3'd6, 10'd10, 10'd12, 16'd4, 2'd0);
        play_en = 1'b1;
        @(negedge clk);
        prof_sel = 3'd6; update = 1'b1;
        @(negedge clk);
        update = 1'b0;
        repeat (6) @(negedge clk);
        chk(smp_valid && freq_out == pat(10'd11), "R12", "second sample before clash",
            freq_out, pat(10'd11));
        repeat (3) @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
        chk(!smp_valid && !done && freq_out == pat(10'd11), "R12", "clash edge quiet",
            {30'd0, smp_valid, done} ^ freq_out, pat(10'd11));
        @(negedge clk);
        chk(!smp_valid, "R12", "no strobe while priming", 32'(smp_valid), 32'd0);
        @(negedge clk);
        chk(smp_valid && !done && freq_out == pat(10'd10), "R12", "restart word",
            freq_out, pat(10'd10));

        summary();
    end

endmodule